// File: doc/BRIEF.md
# Radix-4 Booth Multiplier with Early Termination

This block is a sequential 32x32 integer multiplier that returns the low 32-bit word of the product. Each busy cycle recodes one overlapping three-bit window of the multiplier into a signed Booth digit (0, ±1 or ±2 times the multiplicand). It adds that multiple, already weighted by its position, into an accumulator. Two multiplier bits are therefore retired per clock.

The block stops as soon as the multiplier bits not yet scanned hold no more information. For an unsigned operand that means they are all zero. For a signed operand it means they all match the sign. Small multipliers therefore finish in a few cycles, while the worst case takes sixteen steps. A caller pulses `start` with the operands and the signedness select, watches `busy`, and takes `product` when `done` pulses.

Top module: `booth_mul`

## Requirements
- R1: While reset is held and after its release, `busy` and `done` are 0 and `product` is 0 until a start is accepted.
- R2: The result in `product` is the low 32 bits of multiplicand times multiplier. This is the same whether the operands are treated as signed or unsigned.
- R3: A start is accepted at a rising edge when `start` is 1 and `busy` is 0. If that edge is k and the operation takes n steps, `done` is 1 for the cycle after edge k+1+n.
- R4: With `isSigned` = 0, n is the smallest value in 0..16 for which every multiplier bit from index 2n-1 upward is 0. Bit index -1 counts as 0, and n is capped at 16.
- R5: With `isSigned` = 1, n is the smallest value in 0..16 for which every multiplier bit from index 2n-1 upward equals bit 31. Bit -1 counts as 0, so an all-ones multiplier takes one step.
- R6: A zero multiplier takes zero steps, so `done` follows the edge after the accepting edge.
- R7: `done` lasts exactly one cycle. `busy` is 1 from the accepting edge until the edge that raises `done`. `busy` and `done` are never 1 together.
- R8: A start that arrives while `busy` is 1 is ignored. It changes neither the running result nor its latency.
- R9: A start presented in the same cycle as `done` is accepted, because `busy` is already 0.
- R10: `product` holds its value from the `done` cycle until the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin a multiply with the present operands |
| isSigned | input | 1 | 1: two's-complement multiplier, 0: unsigned |
| multiplicand | input | 32 | Operand that is scaled by each Booth digit |
| multiplier | input | 32 | Operand that is recoded two bits per clock |
| product | output | 32 | Low word of the product |
| done | output | 1 | One-cycle pulse when `product` is final |
| busy | output | 1 | An operation is in progress |

## Verification
The completion pulse of one operation and the acceptance of the next start can fall in the same cycle. `busy` has dropped by then, so the new request must be taken while the finished result is still visible. The bench provokes this by raising `start` with fresh operands exactly in the cycle where it sees `done`. It then judges that `busy` rises on the next edge, and that the second product and its step count match values computed from the operands alone. A start issued in the middle of a long operation is also checked, to confirm it leaves both the running result and its latency untouched.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  typedef struct packed {
    logic load;
    logic step;
  } mulStrobes_t;

  function automatic logic [31:0] boothTerm(input logic [2:0] trip, input logic [31:0] m);
    logic [31:0] t;
    case (trip)
      3'b001, 3'b010: t = m;
      3'b011:         t = m << 1;
      3'b100:         t = -(m << 1);
      3'b101, 3'b110: t = -m;
      default:        t = '0;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/booth_mul_ctrl.sv
module booth_mul_ctrl
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        tailIdle,
  output mulStrobes_t strobe,
  output logic        done,
  output logic        busy
);
  localparam int ITER = WIDTH / 2;
  localparam int CNT_W = $clog2(ITER + 1);

  logic             busyQ;
  logic             doneQ;
  logic [CNT_W-1:0] stepCnt;
  logic             finish;

  assign finish      = busyQ && (tailIdle || stepCnt == CNT_W'(ITER));
  assign strobe.load = !busyQ && start;
  assign strobe.step = busyQ && !finish;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      doneQ   <= 1'b0;
      stepCnt <= '0;
    end else begin
      doneQ <= 1'b0;
      if (!busyQ) begin
        if (start) begin
          busyQ   <= 1'b1;
          stepCnt <= '0;
        end
      end else if (finish) begin
        busyQ <= 1'b0;
        doneQ <= 1'b1;
      end else begin
        stepCnt <= stepCnt + CNT_W'(1);
      end
    end
  end

  assign done = doneQ;
  assign busy = busyQ;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ); // R7
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(doneQ && busyQ)); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && start && !finish) |=> (busyQ && stepCnt == $past(stepCnt) + CNT_W'(1))); // R8
  AST_STEP_CAP: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> stepCnt <= CNT_W'(ITER)); // R4
  AST_FINISH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    finish |=> (doneQ && !busyQ)); // R3

endmodule

// File: rtl/booth_mul_dp.sv
module booth_mul_dp
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mulStrobes_t      strobe,
  input  logic             isSigned,
  input  logic [WIDTH-1:0] mcandIn,
  input  logic [WIDTH-1:0] mplrIn,
  output logic [WIDTH-1:0] acc,
  output logic             tailIdle
);
  logic [WIDTH:0]   scanReg;
  logic [WIDTH-1:0] mcandSh;
  logic             sgnQ;
  logic             extBit;
  logic [WIDTH-1:0] addend;

  assign extBit   = sgnQ & scanReg[WIDTH];
  assign tailIdle = sgnQ ? ((&scanReg) || !(|scanReg)) : !(|scanReg);

  always_comb begin
    addend = '0;
    if (WIDTH == 32) addend = WIDTH'(boothTerm(scanReg[2:0], 32'(mcandSh)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scanReg <= '0;
      mcandSh <= '0;
      sgnQ    <= 1'b0;
      acc     <= '0;
    end else if (strobe.load) begin
      scanReg <= {mplrIn, 1'b0};
      mcandSh <= mcandIn;
      sgnQ    <= isSigned;
      acc     <= '0;
    end else if (strobe.step) begin
      scanReg <= {extBit, extBit, scanReg[WIDTH:2]};
      mcandSh <= mcandSh << 2;
      acc     <= acc + addend;
    end
  end

  AST_ZERO_MPLR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && mplrIn == '0) |=> tailIdle); // R6
  AST_SIGNED_ONES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && isSigned && (&mplrIn)) |=> (!tailIdle && strobe.step) |=> tailIdle); // R5
  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> acc == '0); // R10

endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             isSigned,
  input  logic [WIDTH-1:0] multiplicand,
  input  logic [WIDTH-1:0] multiplier,
  output logic [WIDTH-1:0] product,
  output logic             done,
  output logic             busy
);
  mulStrobes_t strobe;
  logic        tailIdle;

  booth_mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .tailIdle(tailIdle),
    .strobe(strobe), .done(done), .busy(busy)
  );

  booth_mul_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .isSigned(isSigned),
    .mcandIn(multiplicand), .mplrIn(multiplier),
    .acc(product), .tailIdle(tailIdle)
  );

  AST_PRODUCT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(product)); // R10

endmodule

// File: tb/booth_mul_tb.sv
module booth_mul_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        isSigned = 1'b0;
  logic [31:0] multiplicand = '0;
  logic [31:0] multiplier = '0;
  logic [31:0] product;
  logic        done;
  logic        busy;

  int checkCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  booth_mul u_dut (
    .clk(clk), .rstN(rstN), .start(start), .isSigned(isSigned),
    .multiplicand(multiplicand), .multiplier(multiplier),
    .product(product), .done(done), .busy(busy)
  );

  // {isSigned, multiplicand, multiplier}
  localparam logic [64:0] VEC [12] = '{
    {1'b0, 32'h00000007, 32'h00000000},
    {1'b0, 32'h00000003, 32'h00000001},
    {1'b0, 32'h12345678, 32'h00000005},
    {1'b1, 32'h00001234, 32'hFFFFFFFF},
    {1'b0, 32'h00001234, 32'hFFFFFFFF},
    {1'b1, 32'hFFFFFFFD, 32'hFFFFFFF9},
    {1'b0, 32'hDEADBEEF, 32'h80000000},
    {1'b1, 32'h00000005, 32'h80000000},
    {1'b0, 32'hFFFFFFFF, 32'h0000FFFF},
    {1'b1, 32'h7FFFFFFF, 32'h7FFFFFFF},
    {1'b1, 32'h00000064, 32'hFFFFFF80},
    {1'b0, 32'h00000009, 32'h00010000}
  };

  function automatic int expSteps(input logic [31:0] m, input logic s);
    for (int n = 0; n < 16; n++) begin
      logic refBit;
      bit   same;
      refBit = s ? m[31] : 1'b0;
      same = 1'b1;
      if (n == 0 && refBit != 1'b0) same = 1'b0;
      for (int j = (n == 0 ? 0 : 2 * n - 1); j < 32; j++)
        if (m[j] != refBit) same = 1'b0;
      if (same) return n;
    end
    return 16;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic launch(input logic s, input logic [31:0] a, input logic [31:0] b);
    isSigned = s; multiplicand = a; multiplier = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(output int cyc);
    cyc = 0;
    while (cyc < 40) begin
      @(negedge clk);
      cyc++;
      if (done) break;
    end
  endtask

  initial begin
    int cyc;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", 32'(busy), 32'd0);
    check("R1 done in reset", 32'(done), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 product after reset", product, 32'd0);
    check("R1 busy after reset", 32'(busy), 32'd0);

    // R2 R4 R5 R6: vector walk
    foreach (VEC[i]) begin
      logic        s;
      logic [31:0] a, b;
      {s, a, b} = VEC[i];
      launch(s, a, b);
      check("R7 busy after accept", 32'(busy), 32'd1);
      waitDone(cyc);
      check(s ? "R5 signed latency" : "R4 unsigned latency", 32'(cyc), 32'(expSteps(b, s) + 1));
      check("R2 product", product, a * b);
      check("R7 busy low with done", 32'(busy), 32'd0);
      @(negedge clk);
      check("R7 done single cycle", 32'(done), 32'd0);
    end

    // R6 zero multiplier, signed
    launch(1'b1, 32'h00ABCDEF, 32'h0);
    waitDone(cyc);
    check("R6 zero multiplier latency", 32'(cyc), 32'd1);
    check("R6 zero product", product, 32'd0);

    // R8 start during busy ignored
    launch(1'b0, 32'h00000013, 32'h80000001);
    repeat (4) @(negedge clk);
    isSigned = 1'b1; multiplicand = 32'h55555555; multiplier = 32'h0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(cyc);
    check("R8 latency unchanged", 32'(cyc + 5), 32'd17);
    check("R8 product unchanged", product, 32'h00000013 * 32'h80000001);

    // R10 product holds
    held = product;
    repeat (3) @(negedge clk);
    check("R10 product held", product, held);

    // R9 start in the done cycle
    launch(1'b0, 32'h00000021, 32'h00000300);
    waitDone(cyc);
    check("R9 first done seen", 32'(done), 32'd1);
    launch(1'b1, 32'hFFFFFF00, 32'h00000042);
    check("R9 accepted in done cycle", 32'(busy), 32'd1);
    waitDone(cyc);
    check("R9 second latency", 32'(cyc), 32'(expSteps(32'h42, 1'b1) + 1));
    check("R9 second product", product, 32'hFFFFFF00 * 32'h00000042);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

endmodule